// File: doc/BRIEF.md
# Interrupt Status and Bus-Error Capture Register

This block holds the 32-bit interrupt status word of a bus-mastering network controller. Single-cycle event pulses from the rest of the controller set individual status bits. The host clears a bit by writing a one to its position, and a zero written there leaves the bit as it is. A separate mask register chooses which status bits may drive the single level-sensitive interrupt line. Only a fixed, non-contiguous group of positions can interrupt: bits 0 to 8, 10, 11 and 13.

When the bus master side reports an error, the block sets status bit 13. In the same cycle it stores a 3-bit code that tells what kind of error it was. The host reads this code in bits 25:23. The code is valid only while bit 13 is set, and it never drives the interrupt line. A parity error is reported only while the parity-response enable input is high.

The host reaches both registers through a simple word-wide port. A select input picks the status word or the mask word. The read data is combinational from the stored state.

Top module: `irq_status_unit`

## Requirements
- R1: After reset (asynchronous assertion of `rst_n` low), the status word, the error-type field and the mask word all read as zero, and `irq` is low.
- R2: A one on `evt_set[i]` for any i in 0..22 other than 13 sets status bit i at the next clock edge. The bit stays set until the host clears it.
- R3: A status write (`reg_wr`=1, `reg_sel`=0) clears every status bit in 0..22 whose write-data bit is one. Bits whose write-data bit is zero keep their value.
- R4: When an event and a host clear hit the same status bit in the same cycle, the bit ends up set.
- R5: `irq` is high exactly when at least one status bit in {0..8, 10, 11, 13} is set and the mask bit at the same position is also set. The mask is written and read with `reg_sel`=1.
- R6: Status bits 9, 12 and 14..22 never affect `irq`. Mask positions other than {0..8, 10, 11, 13} ignore writes and read as zero.
- R7: An accepted bus error (`berr_valid`=1) sets status bit 13 and loads `berr_type` into status bits 25:23. The codes are 000 parity, 001 master abort and 010 target abort. Codes 011 and 1xx are reserved but are still stored. A later accepted error replaces the stored code.
- R8: A bus error with code 000 has no effect on the status word while `par_resp_en` is low.
- R9: Clearing bit 13 by a host write also returns bits 25:23 to zero. Bits 31:23 ignore host writes, and bits 31:26 always read as zero. The error-type field never affects `irq`.
- R10: `evt_set[13]` has no effect. Bit 13 is set only through the bus-error inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchronizer |
| reg_sel | input | 1 | Register select: 0 status word, 1 mask word |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data (ones clear bits in the status word) |
| reg_rdata | output | 32 | Read data of the selected register |
| evt_set | input | 23 | One set pulse per status bit 0..22 |
| berr_valid | input | 1 | Bus error report |
| berr_type | input | 3 | Kind of bus error |
| par_resp_en | input | 1 | Enables reporting of parity errors |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-bit word, 23 event-settable bits, a 3-bit error-type field at bit 23 and a two-stage reset synchronizer. With these values every interrupt-capable position can be compared against the positions that cannot interrupt. All three documented error codes, the suppressed parity case, and collisions of a set event with a host clear on an ordinary bit and on the bus-error bit are all in reach. A reset applied in the middle of the run checks that the asynchronous clear of all state takes effect without waiting for a clock edge.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned EVT_W     = 23;
  localparam int unsigned BERR_BIT  = 13;
  localparam int unsigned ETYPE_LSB = 23;
  localparam int unsigned ETYPE_W   = 3;
  localparam int unsigned ZERO_W    = WORD_W - ETYPE_LSB - ETYPE_W;
  // positions allowed to raise the interrupt: 0..8, 10, 11, 13
  localparam logic [WORD_W-1:0] IRQ_CAP = 32'h0000_2DFF;

  typedef enum logic [ETYPE_W-1:0] {
    ET_PARITY  = 3'b000,
    ET_MABORT  = 3'b001,
    ET_TABORT  = 3'b010
  } err_kind_e;
endpackage

// File: rtl/irq_stat_bits.sv
module irq_stat_bits #(
  parameter int unsigned N = 23
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_q;
  logic [N-1:0] q_d;
  logic [N-1:0] q_en;

  // a set pulse has priority over a simultaneous clear
  always_comb begin
    q_en = set_i | clr_i;
    q_d  = set_i | (q_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (q_en[i]) q_q[i] <= q_d[i];
      end
    end
  end

  assign q_o = q_q;

  generate
    for (genvar g = 0; g < N; g++) begin : g_chk
      // R4
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[g] |=> q_q[g]);
      // R3
      w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[g] && !set_i[g]) |=> !q_q[g]);
      // R3
      idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i[g] && !set_i[g]) |=> (q_q[g] == $past(q_q[g])));
    end
  endgenerate
endmodule

// File: rtl/irq_berr_capture.sv
module irq_berr_capture
  import irq_status_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               berr_valid_i,
  input  logic [ETYPE_W-1:0] berr_type_i,
  input  logic               par_en_i,
  input  logic               clr_i,
  output logic               accept_o,
  output logic [ETYPE_W-1:0] type_o
);
  logic [ETYPE_W-1:0] type_q;
  logic [ETYPE_W-1:0] type_d;
  logic               type_en;
  logic               accept;

  always_comb begin
    accept  = berr_valid_i &&
              ((berr_type_i != ET_PARITY) || par_en_i);
    type_en = accept || clr_i;
    type_d  = accept ? berr_type_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
    end else if (type_en) begin
      type_q <= type_d;
    end
  end

  assign accept_o = accept;
  assign type_o   = type_q;

  // R8
  parity_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (berr_valid_i && !par_en_i && (berr_type_i == ET_PARITY)) |-> !accept_o);
  // R7
  type_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> (type_q == $past(berr_type_i)));
  // R9
  type_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !accept_o) |=> (type_q == '0));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] CAP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;
  logic [W-1:0] mask_d;

  always_comb mask_d = wdata_i & CAP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (we_i) begin
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(mask_q));
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  input  logic [EVT_W-1:0]   evt_set,
  input  logic               berr_valid,
  input  logic [ETYPE_W-1:0] berr_type,
  input  logic               par_resp_en,
  output logic               irq
);
  // reset: asserted at once, released after SYNC_STAGES edges
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[SYNC_STAGES-1];

  logic               stat_wr;
  logic               mask_wr;
  logic [EVT_W-1:0]   stat_clr;
  logic [EVT_W-1:0]   stat_set;
  logic [EVT_W-1:0]   stat_q;
  logic               berr_accept;
  logic [ETYPE_W-1:0] etype_q;
  logic [WORD_W-1:0]  mask_q;
  logic [WORD_W-1:0]  stat_word;

  always_comb begin
    stat_wr  = reg_wr && !reg_sel;
    mask_wr  = reg_wr && reg_sel;
    stat_clr = stat_wr ? reg_wdata[EVT_W-1:0] : '0;
    stat_set = evt_set;
    stat_set[BERR_BIT] = berr_accept;
  end

  irq_stat_bits #(.N(EVT_W)) u_bits (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set_i (stat_set),
    .clr_i (stat_clr),
    .q_o   (stat_q)
  );

  irq_berr_capture u_berr (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .berr_valid_i (berr_valid),
    .berr_type_i  (berr_type),
    .par_en_i     (par_resp_en),
    .clr_i        (stat_clr[BERR_BIT]),
    .accept_o     (berr_accept),
    .type_o       (etype_q)
  );

  irq_mask_reg #(.W(WORD_W), .CAP(IRQ_CAP)) u_mask (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .we_i    (mask_wr),
    .wdata_i (reg_wdata),
    .mask_o  (mask_q)
  );

  always_comb begin
    stat_word = {{ZERO_W{1'b0}}, etype_q, stat_q};
    reg_rdata = reg_sel ? mask_q : stat_word;
    irq       = |(stat_word & mask_q & IRQ_CAP);
  end

  // R9
  type_needs_bit13_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (etype_q != '0) |-> stat_q[BERR_BIT]);
  // R10
  bit13_source_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!berr_accept && !stat_q[BERR_BIT]) |=> !stat_q[BERR_BIT]);
endmodule

// File: tb/irq_status_unit_tb_top.sv
module irq_status_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_sel;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [22:0] evt_set;
  logic        berr_valid;
  logic [2:0]  berr_type;
  logic        par_resp_en;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_status_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
    .berr_valid(berr_valid), .berr_type(berr_type),
    .par_resp_en(par_resp_en), .irq(irq)
  );

  // vector: op[70:69] data[68:37] etype[36:34] pen[33] exp_stat[32:1] exp_irq[0]
  // op 0 event, 1 status write, 2 mask write, 3 bus error
  localparam int NV = 14;
  localparam logic [70:0] VEC [0:NV-1] = '{
    {2'd2, 32'hFFFF_FFFF, 3'd0, 1'b0, 32'h0000_0000, 1'b0},
    {2'd0, 32'h0000_0001, 3'd0, 1'b0, 32'h0000_0001, 1'b1},
    {2'd0, 32'h0000_1200, 3'd0, 1'b0, 32'h0000_1201, 1'b1},
    {2'd1, 32'h0000_0001, 3'd0, 1'b0, 32'h0000_1200, 1'b0},
    {2'd0, 32'h0000_2000, 3'd0, 1'b0, 32'h0000_1200, 1'b0},
    {2'd3, 32'h0000_0000, 3'd0, 1'b0, 32'h0000_1200, 1'b0},
    {2'd3, 32'h0000_0000, 3'd1, 1'b0, 32'h0080_3200, 1'b1},
    {2'd3, 32'h0000_0000, 3'd2, 1'b0, 32'h0100_3200, 1'b1},
    {2'd1, 32'hFF80_0000, 3'd0, 1'b0, 32'h0100_3200, 1'b1},
    {2'd1, 32'h0000_2000, 3'd0, 1'b0, 32'h0000_1200, 1'b0},
    {2'd3, 32'h0000_0000, 3'd0, 1'b1, 32'h0000_3200, 1'b1},
    {2'd1, 32'h0000_0000, 3'd0, 1'b0, 32'h0000_3200, 1'b1},
    {2'd2, 32'h0000_0000, 3'd0, 1'b0, 32'h0000_3200, 1'b0},
    {2'd1, 32'hFFFF_FFFF, 3'd0, 1'b0, 32'h0000_0000, 1'b0}
  };

  function automatic string vec_tag(int k);
    case (k)
      0: return "R6 mask write";
      1: return "R2 R5 event bit0";
      2: return "R2 events bits 9,12";
      3: return "R3 R6 clear bit0";
      4: return "R10 evt bit13 ignored";
      5: return "R8 parity suppressed";
      6: return "R7 master abort";
      7: return "R7 target abort overwrite";
      8: return "R9 high bits write ignored";
      9: return "R9 type cleared with bit13";
      10: return "R7 parity accepted";
      11: return "R3 zero write holds";
      12: return "R5 mask off";
      default: return "R3 clear all";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0; evt_set = '0;
    berr_valid = 1'b0; berr_type = '0; par_resp_en = 1'b0;
  endtask

  task automatic read_stat(output logic [31:0] v);
    reg_sel = 1'b0; #1; v = reg_rdata;
  endtask

  task automatic read_mask(output logic [31:0] v);
    reg_sel = 1'b1; #1; v = reg_rdata; reg_sel = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    read_stat(rd); chk("R1 status after reset", rd, 32'h0);
    read_mask(rd); chk("R1 mask after reset", rd, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      logic [70:0] v;
      v = VEC[k];
      @(negedge clk);
      case (v[70:69])
        2'd0: evt_set = v[59:37];
        2'd1: begin reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = v[68:37]; end
        2'd2: begin reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = v[68:37]; end
        default: begin berr_valid = 1'b1; berr_type = v[36:34]; par_resp_en = v[33]; end
      endcase
      @(negedge clk);
      idle();
      read_stat(rd);
      chk(vec_tag(k), rd, v[32:1]);
      chk(vec_tag(k), {31'b0, irq}, {31'b0, v[0]});
    end

    // R6 mask readback keeps only the interrupt-capable positions
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    idle();
    read_mask(rd); chk("R6 mask readback", rd, 32'h0000_2DFF);

    // R4 event and clear on bit 3 together
    @(negedge clk);
    evt_set = 23'h8; reg_wr = 1'b1; reg_wdata = 32'h8;
    @(negedge clk);
    idle();
    read_stat(rd); chk("R4 set beats clear bit3", rd, 32'h0000_0008);

    // R4 R7 bus error collides with clearing bit 13
    @(negedge clk);
    berr_valid = 1'b1; berr_type = 3'd2;
    @(negedge clk);
    berr_valid = 1'b1; berr_type = 3'd1; reg_wr = 1'b1; reg_wdata = 32'h2000;
    @(negedge clk);
    idle();
    read_stat(rd); chk("R4 R7 berr beats clear", rd, 32'h0080_2008);
    chk("R5 irq with bits 3 and 13", {31'b0, irq}, 32'h1);

    // R7 reserved code still stored
    @(negedge clk);
    berr_valid = 1'b1; berr_type = 3'd5;
    @(negedge clk);
    idle();
    read_stat(rd); chk("R7 reserved code stored", rd, 32'h0280_2008);

    // R1 asynchronous reset mid-run
    @(negedge clk);
    #3 rst_n = 1'b0;
    #1;
    read_stat(rd); chk("R1 status after mid reset", rd, 32'h0);
    read_mask(rd); chk("R1 mask after mid reset", rd, 32'h0);
    chk("R1 irq after mid reset", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finish_run();
  end
endmodule